// File: doc/BRIEF.md
# Two-Channel Vectored Interrupt Controller

This block raises a single bus interrupt request on behalf of two sources inside a synchronous serial line interface. The higher-priority channel gathers receive events: a received character, a receive status event, and a modem line change. The modem line change counts only when a separate modem enable is also set. The lower-priority channel gathers the transmit-buffer-empty event. Each channel has an interrupt enable bit stored in this block. Software writes these bits with a strobe and can read them back. A channel becomes pending only on a rising edge of its qualified condition. It stays pending while that condition holds, until it is serviced.

The processor answers the request with an acknowledge that travels along a daisy chain, together with a data-in strobe. If this block is requesting, it stops the acknowledge and raises a vector-enable output. The vector carries one channel bit (vector bit 2) that tells the two channels apart. If the block is not requesting, it passes the acknowledge downstream. Any software access to a receive register clears the receive pending state and masks the receive condition for a fixed number of clock cycles. A receive or modem event that is still present when the mask lifts is then seen as a new rising edge and is not lost.

Top module: `dual_vec_irq`

## Requirements
- R1: The receive channel's qualified condition is `rx_ie & (rx_data_ready | rx_status_ready | (modem_change & modem_ie))`. A rising edge of this condition, outside the hold-off window, sets the receive pending state. `irq` is high from the clock edge that samples the rising edge.
- R2: While `modem_ie` is 0, `modem_change` alone never causes a request.
- R3: A rising edge of `tx_ie & tx_buf_empty` sets the transmit pending state. `irq` is high from the clock edge that samples that edge.
- R4: When both channels are pending at the acknowledge, the receive channel is serviced first and `vec_b2` is 0. A transmit service drives `vec_b2` to 1. `vec_b2` is 0 whenever `vec_en` is 0.
- R5: With the block idle and requesting, `iak_in` and `din_strobe` both high at a clock edge raise `vec_en` from that edge. `vec_en` stays high until either input is low at an edge, and `iak_out` stays low throughout.
- R6: The serviced channel's pending state clears at the edge that raises `vec_en`. The channel requests again only after its qualified condition falls and then rises again.
- R7: With the block idle and not requesting, `iak_in` high at an edge raises `iak_out` from that edge. `iak_out` stays high until `iak_in` is low at an edge, even if a request appears in the meantime. No vector is driven while the acknowledge is being passed.
- R8: A cycle with `rx_reg_touch` high clears the receive pending state. It also masks the receive condition for HOLD_CYC clock edges, starting with the edge that samples the touch. A condition still present after the window sets the receive pending state at the next edge.
- R9: `ie_wr_rx` and `ie_wr_tx` load `ie_wdata` into the receive and transmit enable bits at the clock edge. `rx_ie` and `tx_ie` show the stored bits.
- R10: A pending channel whose qualified condition falls before it is serviced stops requesting at the next edge.
- R11: While `rst_n` is low, all outputs are 0 and both enable bits are cleared.
- R12: A receive register touch has no effect on the transmit pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 ns per cycle in the target system |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data_ready | input | 1 | Received character available |
| rx_status_ready | input | 1 | Receive status event available |
| modem_change | input | 1 | Modem line change detected |
| modem_ie | input | 1 | Modem change interrupt enable, held in the receive control register |
| tx_buf_empty | input | 1 | Transmit buffer empty |
| rx_reg_touch | input | 1 | Software accessed the receive control or receive data register this cycle |
| ie_wr_rx | input | 1 | Write strobe for the receive interrupt enable bit |
| ie_wr_tx | input | 1 | Write strobe for the transmit interrupt enable bit |
| ie_wdata | input | 1 | Value to write into the enable bit that is strobed |
| rx_ie | output | 1 | Stored receive interrupt enable |
| tx_ie | output | 1 | Stored transmit interrupt enable |
| iak_in | input | 1 | Daisy-chained interrupt acknowledge, arriving from upstream |
| din_strobe | input | 1 | Bus data-in strobe |
| irq | output | 1 | Bus interrupt request |
| vec_en | output | 1 | Drive the interrupt vector onto the bus |
| vec_b2 | output | 1 | Vector bit 2: 1 for the transmit channel, 0 for the receive channel |
| iak_out | output | 1 | Acknowledge passed downstream |

## Verification
The bench builds the block with the default HOLD_CYC of 6, which is 600 ns at a 100 ns clock. With this value the whole hold-off window can be crossed inside a directed sequence. The exact count of masked edges before the re-request is checked against the value expected for 6. At this size the window can also overlap an acknowledge, a transmit request and a further register touch within a few cycles, so each of these interactions is exercised.

// File: rtl/dual_vec_irq_pkg.sv
package dual_vec_irq_pkg;

    // Acknowledge handling phases
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_SERVE = 2'd1,
        ACK_PASS  = 2'd2
    } ack_state_e;

    // Channel indices; lower index has higher priority
    localparam int CH_RX = 0;
    localparam int CH_TX = 1;
    localparam int N_CH  = 2;

    typedef struct packed {
        logic seen;   // qualified condition at the previous edge
        logic pend;   // channel is requesting
    } chan_state_t;

    typedef struct packed {
        ack_state_e st;
        logic       serv_tx;
    } ack_reg_t;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
    } ie_reg_t;

endpackage

// File: rtl/dual_vec_irq_chan.sv
module dual_vec_irq_chan
    import dual_vec_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic clr_i,
    output logic pend_o
);

    chan_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = cond_i;
        // set on a fresh rising edge, hold while the condition stays up
        st_d.pend = ~clr_i & ((cond_i & ~st_q.seen) | (st_q.pend & cond_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/dual_vec_irq_holdoff.sv
module dual_vec_irq_holdoff #(
    parameter int HOLD_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic touch_i,
    output logic blank_o
);

    localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (touch_i) begin
            st_d.left = RELOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the touch cycle itself plus HOLD_CYC-1 following edges
    assign blank_o = touch_i | (st_q.left != '0);

endmodule

// File: rtl/dual_vec_irq_ack.sv
module dual_vec_irq_ack
    import dual_vec_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iak_i,
    input  logic din_i,
    input  logic rx_pend_i,
    input  logic tx_pend_i,
    output logic clr_rx_o,
    output logic clr_tx_o,
    output logic vec_en_o,
    output logic vec_tx_o,
    output logic pass_o
);

    ack_reg_t st_d, st_q;
    logic     ack_both;
    logic     any_pend;

    always_comb begin
        st_d     = st_q;
        ack_both = iak_i & din_i;
        any_pend = rx_pend_i | tx_pend_i;
        clr_rx_o = 1'b0;
        clr_tx_o = 1'b0;
        unique case (st_q.st)
            ACK_IDLE: begin
                if (ack_both && any_pend) begin
                    st_d.st      = ACK_SERVE;
                    st_d.serv_tx = ~rx_pend_i;
                    clr_rx_o     = rx_pend_i;
                    clr_tx_o     = ~rx_pend_i;
                end else if (iak_i && !any_pend) begin
                    st_d.st = ACK_PASS;
                end
            end
            ACK_SERVE: begin
                if (!ack_both) begin
                    st_d.st      = ACK_IDLE;
                    st_d.serv_tx = 1'b0;
                end
            end
            ACK_PASS: begin
                if (!iak_i) st_d.st = ACK_IDLE;
            end
            default: st_d.st = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st      <= ACK_IDLE;
            st_q.serv_tx <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_en_o = (st_q.st == ACK_SERVE);
    assign vec_tx_o = (st_q.st == ACK_SERVE) & st_q.serv_tx;
    assign pass_o   = (st_q.st == ACK_PASS);

endmodule

// File: rtl/dual_vec_irq.sv
module dual_vec_irq
    import dual_vec_irq_pkg::*;
#(
    parameter int HOLD_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data_ready,
    input  logic rx_status_ready,
    input  logic modem_change,
    input  logic modem_ie,
    input  logic tx_buf_empty,
    input  logic rx_reg_touch,
    input  logic ie_wr_rx,
    input  logic ie_wr_tx,
    input  logic ie_wdata,
    output logic rx_ie,
    output logic tx_ie,
    input  logic iak_in,
    input  logic din_strobe,
    output logic irq,
    output logic vec_en,
    output logic vec_b2,
    output logic iak_out
);

    ie_reg_t ie_d, ie_q;

    logic            rx_blank;
    logic            rx_raw;
    logic [N_CH-1:0] chan_cond;
    logic [N_CH-1:0] chan_clr;
    logic [N_CH-1:0] chan_pend;
    logic            ack_clr_rx;
    logic            ack_clr_tx;

    // enable bits held here, written by software strobes
    always_comb begin
        ie_d = ie_q;
        if (ie_wr_rx) ie_d.rx_ie = ie_wdata;
        if (ie_wr_tx) ie_d.tx_ie = ie_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ie_q <= '0;
        else        ie_q <= ie_d;
    end

    assign rx_ie = ie_q.rx_ie;
    assign tx_ie = ie_q.tx_ie;

    // source qualification
    assign rx_raw = ie_q.rx_ie &
                    (rx_data_ready | rx_status_ready | (modem_change & modem_ie));

    assign chan_cond[CH_RX] = rx_raw & ~rx_blank;
    assign chan_cond[CH_TX] = ie_q.tx_ie & tx_buf_empty;
    assign chan_clr[CH_RX]  = ack_clr_rx;
    assign chan_clr[CH_TX]  = ack_clr_tx;

    dual_vec_irq_holdoff #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .touch_i (rx_reg_touch),
        .blank_o (rx_blank)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        dual_vec_irq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (chan_cond[ch]),
            .clr_i  (chan_clr[ch]),
            .pend_o (chan_pend[ch])
        );
    end

    dual_vec_irq_ack u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .iak_i     (iak_in),
        .din_i     (din_strobe),
        .rx_pend_i (chan_pend[CH_RX]),
        .tx_pend_i (chan_pend[CH_TX]),
        .clr_rx_o  (ack_clr_rx),
        .clr_tx_o  (ack_clr_tx),
        .vec_en_o  (vec_en),
        .vec_tx_o  (vec_b2),
        .pass_o    (iak_out)
    );

    assign irq = |chan_pend;

endmodule

// File: rtl/dual_vec_irq_chk.sv
module dual_vec_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_data_ready,
    input logic rx_status_ready,
    input logic modem_change,
    input logic modem_ie,
    input logic tx_buf_empty,
    input logic rx_reg_touch,
    input logic ie_wr_rx,
    input logic ie_wdata,
    input logic rx_ie,
    input logic tx_ie,
    input logic iak_in,
    input logic din_strobe,
    input logic irq,
    input logic vec_en,
    input logic vec_b2,
    input logic iak_out,
    input logic rx_pend,
    input logic tx_pend,
    input logic rx_blank
);

    // R1
    rx_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pend) |-> $past(rx_ie && (rx_data_ready || rx_status_ready ||
                                           (modem_change && modem_ie))));

    // R2
    modem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_pend) |-> $past(rx_data_ready || rx_status_ready || modem_ie));

    // R3
    tx_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_pend) |-> $past(tx_ie && tx_buf_empty));

    // R4
    b2_only_in_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_b2 |-> vec_en);

    // R5
    vec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_en) |-> $past(iak_in && din_strobe && irq));

    // R5
    vec_pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_en && iak_out));

    // R6
    rx_served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_en) && !vec_b2) |-> !rx_pend);

    // R6
    tx_served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_en) && vec_b2) |-> !tx_pend);

    // R7
    pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iak_out) |-> $past(iak_in && !irq));

    // R8
    touch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reg_touch |=> !rx_pend);

    // R8
    blank_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_blank |=> !$rose(rx_pend));

    // R9
    rx_ie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ie_wr_rx |=> (rx_ie == $past(ie_wdata)));

endmodule

bind dual_vec_irq dual_vec_irq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_data_ready   (rx_data_ready),
    .rx_status_ready (rx_status_ready),
    .modem_change    (modem_change),
    .modem_ie        (modem_ie),
    .tx_buf_empty    (tx_buf_empty),
    .rx_reg_touch    (rx_reg_touch),
    .ie_wr_rx        (ie_wr_rx),
    .ie_wdata        (ie_wdata),
    .rx_ie           (rx_ie),
    .tx_ie           (tx_ie),
    .iak_in          (iak_in),
    .din_strobe      (din_strobe),
    .irq             (irq),
    .vec_en          (vec_en),
    .vec_b2          (vec_b2),
    .iak_out         (iak_out),
    .rx_pend         (chan_pend[0]),
    .tx_pend         (chan_pend[1]),
    .rx_blank        (rx_blank)
);

// File: tb/dual_vec_irq_tb.sv
module dual_vec_irq_tb;

    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data_ready = 0, rx_status_ready = 0, modem_change = 0, modem_ie = 0;
    logic tx_buf_empty = 0, rx_reg_touch = 0;
    logic ie_wr_rx = 0, ie_wr_tx = 0, ie_wdata = 0;
    logic iak_in = 0, din_strobe = 0;
    logic rx_ie, tx_ie, irq, vec_en, vec_b2, iak_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_rxp, m_txp, m_rxc_prev, m_txc_prev, m_rx_ie, m_tx_ie, m_serv_tx;
    int m_left;
    int m_phase;   // 0 idle, 1 vector, 2 passing

    always #4 clk = ~clk;

    dual_vec_irq #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_data_ready(rx_data_ready), .rx_status_ready(rx_status_ready),
        .modem_change(modem_change), .modem_ie(modem_ie),
        .tx_buf_empty(tx_buf_empty), .rx_reg_touch(rx_reg_touch),
        .ie_wr_rx(ie_wr_rx), .ie_wr_tx(ie_wr_tx), .ie_wdata(ie_wdata),
        .rx_ie(rx_ie), .tx_ie(tx_ie),
        .iak_in(iak_in), .din_strobe(din_strobe),
        .irq(irq), .vec_en(vec_en), .vec_b2(vec_b2), .iak_out(iak_out)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock: predict from current inputs, cross the edge, compare at negedge
    task automatic tick();
        bit raw, blank, rxc, txc, anyp, n_rxp, n_txp;
        if (!rst_n) begin
            m_rxp = 0; m_txp = 0; m_rxc_prev = 0; m_txc_prev = 0;
            m_rx_ie = 0; m_tx_ie = 0; m_serv_tx = 0; m_left = 0; m_phase = 0;
        end else begin
            raw   = m_rx_ie && (rx_data_ready || rx_status_ready || (modem_change && modem_ie));
            blank = rx_reg_touch || (m_left > 0);
            rxc   = raw && !blank;
            txc   = m_tx_ie && tx_buf_empty;
            anyp  = m_rxp || m_txp;
            n_rxp = (rxc && !m_rxc_prev) || (m_rxp && rxc);
            n_txp = (txc && !m_txc_prev) || (m_txp && txc);
            if (m_phase == 0) begin
                if (iak_in && din_strobe && anyp) begin
                    m_phase = 1;
                    m_serv_tx = !m_rxp;
                    if (m_rxp) n_rxp = 0; else n_txp = 0;
                end else if (iak_in && !anyp) m_phase = 2;
            end else if (m_phase == 1) begin
                if (!(iak_in && din_strobe)) begin m_phase = 0; m_serv_tx = 0; end
            end else if (!iak_in) m_phase = 0;
            if (rx_reg_touch) m_left = HOLD - 1;
            else if (m_left > 0) m_left--;
            if (ie_wr_rx) m_rx_ie = ie_wdata;
            if (ie_wr_tx) m_tx_ie = ie_wdata;
            m_rxp = n_rxp; m_txp = n_txp;
            m_rxc_prev = rxc; m_txc_prev = txc;
        end
        @(posedge clk);
        @(negedge clk);
        check("R1", "irq(model)", irq, m_rxp || m_txp);
        check("R5", "vec_en(model)", vec_en, m_phase == 1);
        check("R4", "vec_b2(model)", vec_b2, (m_phase == 1) && m_serv_tx);
        check("R7", "iak_out(model)", iak_out, m_phase == 2);
        check("R9", "rx_ie(model)", rx_ie, m_rx_ie);
        check("R9", "tx_ie(model)", tx_ie, m_tx_ie);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        ticks(3);
        // R11 reset state
        check("R11", "irq in reset", irq, 1'b0);
        check("R11", "vec_en in reset", vec_en, 1'b0);
        check("R11", "iak_out in reset", iak_out, 1'b0);
        check("R11", "rx_ie in reset", rx_ie, 1'b0);
        rst_n = 1;
        tick();

        // R9 enable writes
        ie_wr_rx = 1; ie_wdata = 1; tick();
        check("R9", "rx_ie after write", rx_ie, 1'b1);
        ie_wr_rx = 0; ie_wr_tx = 1; tick();
        check("R9", "tx_ie after write", tx_ie, 1'b1);
        ie_wr_tx = 0; ie_wdata = 0; tick();

        // R1 data ready request and R5/R6 service
        rx_data_ready = 1; tick();
        check("R1", "irq after data ready", irq, 1'b1);
        iak_in = 1; din_strobe = 1; tick();
        check("R5", "vec_en on ack", vec_en, 1'b1);
        check("R4", "vec_b2 rx service", vec_b2, 1'b0);
        check("R6", "irq cleared by service", irq, 1'b0);
        check("R5", "iak_out held low", iak_out, 1'b0);
        tick();
        check("R5", "vec_en held", vec_en, 1'b1);
        iak_in = 0; din_strobe = 0; tick();
        check("R5", "vec_en released", vec_en, 1'b0);
        ticks(2);
        check("R6", "no re-request on held level", irq, 1'b0);
        rx_data_ready = 0; tick();
        rx_data_ready = 1; tick();
        check("R6", "re-request on new edge", irq, 1'b1);
        rx_data_ready = 0; tick();
        // R10 condition fell before service
        check("R10", "irq drops with condition", irq, 1'b0);

        // R2 modem change gating
        modem_change = 1; ticks(2);
        check("R2", "modem change without enable", irq, 1'b0);
        modem_ie = 1; tick();
        check("R1", "modem change with enable", irq, 1'b1);
        iak_in = 1; din_strobe = 1; tick();
        iak_in = 0; din_strobe = 0; modem_change = 0; ticks(2);

        // R3 transmit request
        tx_buf_empty = 1; tick();
        check("R3", "irq on tx empty", irq, 1'b1);
        iak_in = 1; din_strobe = 1; tick();
        check("R4", "vec_b2 tx service", vec_b2, 1'b1);
        iak_in = 0; din_strobe = 0; tx_buf_empty = 0; ticks(2);

        // R4 priority with both pending
        rx_status_ready = 1; tx_buf_empty = 1; tick();
        iak_in = 1; din_strobe = 1; tick();
        check("R4", "rx wins first", vec_b2, 1'b0);
        check("R4", "tx still requesting", irq, 1'b1);
        iak_in = 0; din_strobe = 0; tick();
        iak_in = 1; din_strobe = 1; tick();
        check("R4", "tx served second", vec_b2, 1'b1);
        check("R6", "all served", irq, 1'b0);
        iak_in = 0; din_strobe = 0; rx_status_ready = 0; tx_buf_empty = 0; ticks(2);

        // iak without data-in while requesting: no vector, no pass
        rx_data_ready = 1; tick();
        iak_in = 1; ticks(2);
        check("R5", "no vector without data-in", vec_en, 1'b0);
        check("R7", "no pass while requesting", iak_out, 1'b0);
        iak_in = 0; rx_data_ready = 0; ticks(2);

        // R7 pass-through, request arising mid-pass
        iak_in = 1; tick();
        check("R7", "ack passed", iak_out, 1'b1);
        rx_status_ready = 1; tick();
        check("R7", "pass held with new request", iak_out, 1'b1);
        din_strobe = 1; tick();
        check("R7", "no vector while passing", vec_en, 1'b0);
        iak_in = 0; din_strobe = 0; tick();
        check("R7", "pass released", iak_out, 1'b0);
        iak_in = 1; din_strobe = 1; tick();
        iak_in = 0; din_strobe = 0; rx_status_ready = 0; ticks(2);

        // R8 hold-off window length with condition held
        rx_status_ready = 1; tick();
        check("R8", "pending before touch", irq, 1'b1);
        rx_reg_touch = 1; tick();
        check("R8", "touch clears request", irq, 1'b0);
        rx_reg_touch = 0;
        for (int i = 0; i < HOLD - 1; i++) begin
            tick();
            check("R8", "masked inside window", irq, 1'b0);
        end
        tick();
        check("R8", "fresh edge after window", irq, 1'b1);
        rx_status_ready = 0; ticks(2);

        // R12 tx unaffected by rx touch
        tx_buf_empty = 1; tick();
        rx_reg_touch = 1; tick();
        rx_reg_touch = 0;
        check("R12", "tx survives rx touch", irq, 1'b1);
        ticks(3);
        check("R12", "tx still pending", irq, 1'b1);
        tx_buf_empty = 0; tick();

        // touch during modem event, retouch inside window
        modem_change = 1; tick();
        rx_reg_touch = 1; tick();
        rx_reg_touch = 0; ticks(2);
        rx_reg_touch = 1; tick();
        rx_reg_touch = 0; ticks(HOLD + 1);
        check("R8", "modem event seen after retouch", irq, 1'b1);
        modem_change = 0; tick();

        // disable both channels
        ie_wr_rx = 1; ie_wr_tx = 1; ie_wdata = 0; tick();
        ie_wr_rx = 0; ie_wr_tx = 0;
        rx_data_ready = 1; tx_buf_empty = 1; ticks(2);
        check("R9", "disabled channels silent", irq, 1'b0);
        rx_data_ready = 0; tx_buf_empty = 0; tick();

        done = 1;
        summary();
        $finish;
    end

endmodule